// File: doc/BRIEF.md
# Four-Phase Fetch/Execute Pipeline Sequencer

This block is the timing and control core of a small accumulator-style processor. A free-running oscillator clock is split into four one-hot phase strobes per instruction cycle. These strobes step a two-stage pipeline. While one instruction executes, the next one is fetched from program memory. A straight-line program therefore retires one instruction per instruction cycle.

The block owns the program counter, a prefetch latch and the execute register. It also produces phase-qualified read and write strobes for data memory, and a divided clock output. A small stub decoder only recognises branch words. When the surrounding logic requests a branch while a branch word is executing, the counter is loaded with the target. The word already fetched behind the branch is squashed into a bubble. The target therefore executes two instruction cycles after the branch.

Top module: `quad_phase_pipe`

## Requirements
- R1: The phase output is always one-hot (bit 0 = Q1, bit 1 = Q2, bit 2 = Q3, bit 3 = Q4) and advances one position per oscillator clock in the order Q1, Q2, Q3, Q4, Q1.
- R2: clk_out is high during Q1 and Q2 and low during Q3 and Q4.
- R3: imem_addr changes only on entry to Q1. When no branch is taken, it increases by one.
- R4: The word on imem_rdata is latched at the end of Q3 and enters the execute slot on entry to Q1. The word at address A, presented during one instruction cycle, is on ex_word with ex_valid high during the next cycle, so sequential code completes one word per cycle.
- R5: In a cycle with ex_valid high, dm_rd is high during Q2 only and dm_wr is high during Q4 only. Neither strobe is ever high in any other phase.
- R6: ex_branch is high exactly when ex_valid is high and bits [IW-1:IW-3] of ex_word equal 3'b101. Other opcodes, such as 3'b111, are not branches.
- R7: If br_req is high at the end of Q4 while a branch word executes, imem_addr equals br_target in the next cycle. In that cycle the execute slot is a bubble: ex_valid is low and neither dm_rd nor dm_wr pulses. The word at br_target executes in the cycle after the bubble.
- R8: br_req has no effect while a non-branch word or a bubble is in the execute slot. imem_addr then simply increments.
- R9: In reset, the phase is Q1, imem_addr is 0, ex_valid is low, both strobes are low and clk_out is high. The word at address 0 executes in the second instruction cycle after reset is released.
- R10: A branch word executed with br_req low behaves like an ordinary instruction. The next sequential word follows without a bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | PC_W | Program memory address (program counter) |
| imem_rdata | input | IW | Program memory read word |
| dm_rd | output | 1 | Data memory operand read strobe (Q2) |
| dm_wr | output | 1 | Data memory destination write strobe (Q4) |
| br_req | input | 1 | Branch request from execute logic |
| br_target | input | PC_W | Branch target address |
| clk_out | output | 1 | Oscillator divided by four |
| phase | output | 4 | One-hot phase strobes Q1..Q4 |
| ex_word | output | IW | Word in the execute slot |
| ex_valid | output | 1 | Execute slot holds a real instruction |
| ex_branch | output | 1 | Stub decoder: execute word is a branch |

## Verification
The assertions assume that imem_rdata settles to the word at imem_addr before the end of Q3. They also assume that br_req and br_target are meaningful only at the end of Q4, where they are sampled. The stimulus models program memory as a combinational read of the presented address. It changes br_req and br_target only at the falling edge at the start of Q1 and holds them for the whole instruction cycle. This keeps every input stable across the edges that sample it.

// File: rtl/qps_pkg.sv
package qps_pkg;
  localparam int PH_N = 4;
  typedef logic [PH_N-1:0] phase_t;
  localparam phase_t PH_RESET = 4'b0001;

  function automatic phase_t ph_rotate(input phase_t p);
    return {p[PH_N-2:0], p[PH_N-1]};
  endfunction
endpackage

// File: rtl/qps_phase_ring.sv
module qps_phase_ring
  import qps_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_t ph,
  output logic   ck_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_RESET;
      ck_out <= 1'b1;
    end else begin
      ph     <= ph_rotate(ph);
      ck_out <= ph[3] | ph[0];
    end
  end

  // R1
  ph_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(ph) == 1);
  // R1
  ph_order_chk: assert property (@(posedge clk) disable iff (rst)
    ph[3] |=> ph[0]);
  // R2
  ck_high_chk: assert property (@(posedge clk) disable iff (rst)
    (ph[0] | ph[1]) |-> ck_out);
  // R2
  ck_low_chk: assert property (@(posedge clk) disable iff (rst)
    (ph[2] | ph[3]) |-> !ck_out);
endmodule

// File: rtl/qps_fetch.sv
module qps_fetch
  import qps_pkg::*;
#(
  parameter int PC_W = 10,
  parameter int IW   = 14,
  parameter logic [IW-1:0] NOP_WORD = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  phase_t          ph,
  input  logic            take,
  input  logic [PC_W-1:0] target,
  input  logic [IW-1:0]   imem_rdata,
  output logic [PC_W-1:0] pc,
  output logic [IW-1:0]   pf_word
);
  localparam logic [PC_W-1:0] PC_ONE = {{(PC_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      pf_word <= NOP_WORD;
    end else begin
      if (ph[2]) pf_word <= imem_rdata;
      if (ph[3]) pc <= take ? target : pc + PC_ONE;
    end
  end

  // R3
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ph[3] |=> $stable(pc));
  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ph[3] && !take) |=> pc == $past(pc) + PC_ONE);
  // R7
  pc_jump_chk: assert property (@(posedge clk) disable iff (rst)
    (ph[3] && take) |=> pc == $past(target));
endmodule

// File: rtl/qps_exec.sv
module qps_exec
  import qps_pkg::*;
#(
  parameter int IW    = 14,
  parameter int OPC_W = 3,
  parameter logic [OPC_W-1:0] BR_OPC = 3'b101,
  parameter logic [IW-1:0] NOP_WORD = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  phase_t        ph,
  input  logic [IW-1:0] pf_word,
  input  logic          br_req,
  output logic          take,
  output logic [IW-1:0] ir,
  output logic          ir_valid,
  output logic          ir_branch,
  output logic          dm_rd,
  output logic          dm_wr
);
  logic pf_is_br;
  assign pf_is_br = (pf_word[IW-1 -: OPC_W] == BR_OPC);
  assign take     = ph[3] & ir_valid & ir_branch & br_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      ir        <= NOP_WORD;
      ir_valid  <= 1'b0;
      ir_branch <= 1'b0;
      dm_rd     <= 1'b0;
      dm_wr     <= 1'b0;
    end else begin
      if (ph[3]) begin
        ir        <= take ? NOP_WORD : pf_word;
        ir_valid  <= !take;
        ir_branch <= !take && pf_is_br;
      end
      dm_rd <= ph[0] & ir_valid;
      dm_wr <= ph[2] & ir_valid;
    end
  end

  // R5
  rd_phase_chk: assert property (@(posedge clk) disable iff (rst)
    dm_rd |-> ph[1]);
  // R5
  wr_phase_chk: assert property (@(posedge clk) disable iff (rst)
    dm_wr |-> ph[3]);
  // R7
  strobe_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    (dm_rd | dm_wr) |-> ir_valid);
  // R7
  squash_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> (!ir_valid && !ir_branch));
  // R4
  ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ph[3] |=> $stable(ir));
  // R6
  br_valid_chk: assert property (@(posedge clk) disable iff (rst)
    ir_branch |-> ir_valid);
endmodule

// File: rtl/quad_phase_pipe.sv
module quad_phase_pipe
  import qps_pkg::*;
#(
  parameter int PC_W  = 10,
  parameter int IW    = 14,
  parameter int OPC_W = 3,
  parameter logic [OPC_W-1:0] BR_OPC = 3'b101,
  parameter logic [IW-1:0] NOP_WORD = '0
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PC_W-1:0] imem_addr,
  input  logic [IW-1:0]   imem_rdata,
  output logic            dm_rd,
  output logic            dm_wr,
  input  logic            br_req,
  input  logic [PC_W-1:0] br_target,
  output logic            clk_out,
  output logic [3:0]      phase,
  output logic [IW-1:0]   ex_word,
  output logic            ex_valid,
  output logic            ex_branch
);
  phase_t        ph;
  logic          take;
  logic [IW-1:0] pf_word;

  assign phase = ph;

  qps_phase_ring u_ring (
    .clk    (clk),
    .rst    (rst),
    .ph     (ph),
    .ck_out (clk_out)
  );

  qps_fetch #(.PC_W(PC_W), .IW(IW), .NOP_WORD(NOP_WORD)) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .ph         (ph),
    .take       (take),
    .target     (br_target),
    .imem_rdata (imem_rdata),
    .pc         (imem_addr),
    .pf_word    (pf_word)
  );

  qps_exec #(.IW(IW), .OPC_W(OPC_W), .BR_OPC(BR_OPC), .NOP_WORD(NOP_WORD)) u_exec (
    .clk       (clk),
    .rst       (rst),
    .ph        (ph),
    .pf_word   (pf_word),
    .br_req    (br_req),
    .take      (take),
    .ir        (ex_word),
    .ir_valid  (ex_valid),
    .ir_branch (ex_branch),
    .dm_rd     (dm_rd),
    .dm_wr     (dm_wr)
  );
endmodule

// File: tb/quad_phase_pipe_test.sv
`timescale 1ns/1ps
module quad_phase_pipe_test;
  localparam int PC_W = 10;
  localparam int IW   = 14;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [PC_W-1:0] imem_addr;
  logic [IW-1:0]   imem_rdata;
  logic            dm_rd, dm_wr, clk_out, ex_valid, ex_branch;
  logic            br_req = 1'b0;
  logic [PC_W-1:0] br_target = '0;
  logic [3:0]      phase;
  logic [IW-1:0]   ex_word;
  logic [IW-1:0]   mem [64];

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 0;

  // model state
  logic [PC_W-1:0] m_fetch;
  logic [IW-1:0]   m_word;
  logic            m_valid;

  always #2 clk = ~clk;
  assign imem_rdata = mem[imem_addr[5:0]];

  quad_phase_pipe uut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dm_rd(dm_rd), .dm_wr(dm_wr), .br_req(br_req), .br_target(br_target),
    .clk_out(clk_out), .phase(phase), .ex_word(ex_word),
    .ex_valid(ex_valid), .ex_branch(ex_branch)
  );

  function automatic bit is_br(input logic [IW-1:0] w);
    return w[13:11] == 3'b101;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one instruction cycle, starting and ending at the falling edge inside Q1
  task automatic step(input logic req, input logic [PC_W-1:0] tgt);
    logic [3:0] rd_s, wr_s, ck_s;
    bit taken;
    br_req    = req;
    br_target = tgt;
    for (int p = 0; p < 4; p++) begin
      chk(phase == (4'b0001 << p), "R1 phase order", 32'(phase), 32'(4'b0001 << p));
      rd_s[p] = dm_rd;
      wr_s[p] = dm_wr;
      ck_s[p] = clk_out;
      @(negedge clk);
    end
    chk(ck_s == 4'b0011, "R2 clk_out pattern", 32'(ck_s), 32'h3);
    chk(rd_s == (m_valid ? 4'b0010 : 4'b0000), "R5/R7 dm_rd pattern", 32'(rd_s),
        m_valid ? 32'h2 : 32'h0);
    chk(wr_s == (m_valid ? 4'b1000 : 4'b0000), "R5/R7 dm_wr pattern", 32'(wr_s),
        m_valid ? 32'h8 : 32'h0);
    taken = m_valid && is_br(m_word) && req;
    if (taken) begin
      m_valid = 1'b0;
      m_fetch = tgt;
    end else begin
      m_word  = mem[m_fetch[5:0]];
      m_valid = 1'b1;
      m_fetch = m_fetch + 1'b1;
    end
    br_req = 1'b0;
    chk(imem_addr == m_fetch, "R3/R7/R8 imem_addr", 32'(imem_addr), 32'(m_fetch));
    chk(ex_valid == m_valid, "R4/R7 ex_valid", 32'(ex_valid), 32'(m_valid));
    if (m_valid)
      chk(ex_word == m_word, "R4 ex_word", 32'(ex_word), 32'(m_word));
    chk(ex_branch == (m_valid && is_br(m_word)), "R6 ex_branch", 32'(ex_branch),
        32'(m_valid && is_br(m_word)));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(phase == 4'b0001, "R9 reset phase", 32'(phase), 32'h1);
    chk(imem_addr == '0, "R9 reset pc", 32'(imem_addr), 32'h0);
    chk(!ex_valid && !dm_rd && !dm_wr, "R9 reset strobes/valid",
        32'({ex_valid, dm_rd, dm_wr}), 32'h0);
    chk(clk_out == 1'b1, "R9 reset clk_out", 32'(clk_out), 32'h1);
    rst = 1'b0;
    m_fetch = '0;
    m_valid = 1'b0;
    m_word  = '0;
    // first cycle is a bubble; address 0 executes in the second (R9)
    step(1'b0, '0);
    chk(ex_word == mem[0] && ex_valid, "R9 first word at address 0",
        32'(ex_word), 32'(mem[0]));
  endtask

  task automatic t_linear();
    // R4: sequential words, one per cycle
    for (int i = 0; i < 4; i++) step(1'b0, '0);
  endtask

  task automatic t_branch_taken();
    // R7: branch at address 5 to 40
    for (int i = 0; i < 10 && !(m_valid && is_br(m_word)); i++) step(1'b0, '0);
    chk(ex_word == mem[5], "R7 branch word in execute", 32'(ex_word), 32'(mem[5]));
    step(1'b1, 10'd40);
    chk(!ex_valid && imem_addr == 10'd40, "R7 bubble and target fetch",
        32'({ex_valid, imem_addr}), 32'(10'd40));
    // R8: request during the bubble is ignored
    step(1'b1, 10'd60);
    chk(ex_word == mem[40] && imem_addr == 10'd41, "R7/R8 target executes",
        32'(imem_addr), 32'd41);
  endtask

  task automatic t_not_taken();
    // run to the branch at 44, R10: no request -> no bubble
    for (int i = 0; i < 10 && !(m_valid && is_br(m_word)); i++) step(1'b0, '0);
    step(1'b0, 10'd60);
    chk(ex_valid && ex_word == mem[45], "R10 sequential after untaken branch",
        32'(ex_word), 32'(mem[45]));
  endtask

  task automatic t_ignored();
    // R8: request with word 45 (non-branch) executing
    step(1'b1, 10'd60);
    chk(ex_word == mem[46] && imem_addr == 10'd47, "R8 request ignored",
        32'(imem_addr), 32'd47);
    // R6: opcode 3'b111 at 46 is not a branch; request ignored
    step(1'b1, 10'd60);
    chk(ex_valid && imem_addr == 10'd48, "R6 non-branch opcode ignored",
        32'(imem_addr), 32'd48);
    step(1'b0, '0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = {3'b000, 11'(i * 3 + 7)};
    mem[5]  = {3'b101, 11'h055};
    mem[44] = {3'b101, 11'h02C};
    mem[46] = {3'b111, 11'h123};
    @(negedge clk);
    t_reset();
    t_linear();
    t_branch_taken();
    t_not_taken();
    t_ignored();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule